// File: doc/BRIEF.md
# Dual-View Security Control Register Bank

This block holds the security configuration of a subsystem's peripheral protection groups and exposes it through two 4 KB register windows. A secure master uses the full window: it sets which ports of each group are non-secure, which are reachable only by privileged secure code, and it enables, clears and observes the security interrupts raised by memory, peripheral and master security filters. A non-secure master reaches the second window. There it can program only the non-secure privilege masks, which share storage with the secure view, and read the identification words.

There are eleven protection groups: one internal AHB group, two internal APB groups, four expansion APB groups and four expansion AHB groups. The block drives each group's non-secure vector and its effective access-permission vector. For every port, the permission bit is the non-secure privilege bit when the port is marked non-secure, and the secure privilege bit otherwise. Filter status lines come in as plain levels and are packed into status words at fixed bit positions. A combined interrupt reports any enabled bit of the master-filter status.

The register port is a plain strobe with no back-pressure. A request is accepted on every cycle in which `bus_en` is high. `bus_ns` selects the window. Read data comes back one cycle later, flagged by `bus_rvalid`.

Top module: `sec_ctrl_bank`

## Requirements
- R1: In the secure window, word offsets whose upper nibble is 5, 6, 7 or 8 write and read the non-secure masks of the internal AHB group (0x50 only), the expansion AHB groups (0x60–0x6C), the internal APB groups (0x70–0x74) and the expansion APB groups (0x80–0x8C). Offsets 0x90–0xCC address the secure privilege masks of the same groups in the same layout. Address bits [3:2] select the instance, and only the low NPORT (16) data bits are stored.
- R2: In the non-secure window, offsets 0x90–0xCC address the non-secure privilege masks of the groups. Every other offset in that window ignores writes and reads zero, apart from the identification words.
- R3: For each group port i, `grp_ap` equals the non-secure privilege bit when `grp_nonsec[i]` is 1, and the secure privilege bit otherwise. `grp_nonsec` shows the stored non-secure mask.
- R4: A write with `bus_size` other than 2 (0 = byte, 1 = half, 2 = word) changes nothing.
- R5: A read returns the aligned word shifted right by 8×`bus_addr[1:0]`. A byte read is masked to 8 bits, a half-word read to 16 bits, and sizes 2 and 3 keep all bits.
- R6: The PPC enable register (0x28) keeps only the bits in 0x00F000F3. The bridge enable register (0x48) keeps only the bits in 0xFFFF0000. `ppc_irq_en[j]` is enable bit j for j = 0, 1, bit j+2 for j = 2–5, and bit j+14 for j = 6–9.
- R7: A word write to 0x14 stores bits [1:0], which drive `nsc_cfg`. A word write to 0x10 stores bit 0, which drives `resp_cfg`. Both read back.
- R8: MPC status (0x1C) has bit 0 = `mpc_int_in` and bit 16+n = `mpc_exp_in[n]`. MSC status (0x30) has bit 16+n = `msc_exp_in[n]`. PPC status (0x20) carries `ppc_stat_in[j]` at the bit that R6 gives for j.
- R9: `msc_irq` is high exactly when the MSC status word ANDed with the MSC enable word (0x38) is non-zero. It follows input changes in the same cycle.
- R10: A secure word write to 0x24 pulses `ppc_irq_clr[j]` for one cycle from the data bit that R6 gives for j. A write to 0x34 pulses `msc_clr[n]` from bit 16+n. A write to 0x4C stores bits 16+n, which drive `msc_ns[n]` and read back at the same bits.
- R11: Bridge status (0x40) and the clear registers (0x24, 0x34, 0x44) read zero. Writes to status offsets and to unmapped offsets have no effect.
- R12: After reset, all masks, enables, configuration outputs and pulses are zero.
- R13: Word k at offsets 0xFD0–0xFFC (k = (offset−0xFD0)/4) reads 0xA0+k in the secure window and 0xC0+k in the non-secure window.
- R14: `bus_rvalid` is high in the cycle after a read request, and only then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Register request strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_ns | input | 1 | Window select: 1 = non-secure window |
| bus_addr | input | 12 | Byte offset within the window |
| bus_size | input | 2 | 0 byte, 1 half, 2 word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after request |
| bus_rvalid | output | 1 | Read data valid |
| mpc_int_in | input | 1 | Internal memory filter interrupt level |
| mpc_exp_in | input | NEXP_MPC | Expansion memory filter interrupt levels |
| msc_exp_in | input | NEXP_MSC | Expansion master filter interrupt levels |
| ppc_stat_in | input | 10 | Peripheral filter interrupt levels |
| grp_nonsec | output | 11×NPORT | Per-group non-secure vectors, group g at [g×NPORT +: NPORT] |
| grp_ap | output | 11×NPORT | Per-group effective privilege vectors |
| ppc_irq_en | output | 10 | Peripheral filter interrupt enables |
| ppc_irq_clr | output | 10 | Peripheral filter clear pulses |
| msc_clr | output | NEXP_MSC | Master filter clear pulses |
| msc_ns | output | NEXP_MSC | Master filter non-secure settings |
| msc_irq | output | 1 | Combined master filter interrupt |
| resp_cfg | output | 1 | Security response configuration |
| nsc_cfg | output | 2 | Non-secure-callable configuration |

Group order: 0 internal AHB, 1–2 internal APB, 3–6 expansion APB, 7–10 expansion AHB.

## Verification
The hardest case to reach is one where the two views alias the same group. The non-secure window writes a privilege mask whose offset, in the secure window, means a different mask, while the port's non-secure bit decides which mask drives `grp_ap`. The random stimulus mixes windows, sizes and offsets inside the mask range and re-checks every group's outputs after each access. Directed sequences cover the narrow-write, lane-extraction, clear-pulse and identification corners.

// File: rtl/scb_pkg.sv
package scb_pkg;
  localparam int NGRP = 11;
  localparam int NIRQ = 10;

  typedef enum logic [1:0] {MK_NONE = 2'd0, MK_NS = 2'd1, MK_SP = 2'd2, MK_NSP = 2'd3} mask_e;

  typedef struct packed {
    mask_e      kind;
    logic [3:0] grp;
  } mref_t;

  localparam logic [11:0] OFF_RESP    = 12'h010;
  localparam logic [11:0] OFF_NSC     = 12'h014;
  localparam logic [11:0] OFF_MPC_ST  = 12'h01C;
  localparam logic [11:0] OFF_PPC_ST  = 12'h020;
  localparam logic [11:0] OFF_PPC_CLR = 12'h024;
  localparam logic [11:0] OFF_PPC_EN  = 12'h028;
  localparam logic [11:0] OFF_MSC_ST  = 12'h030;
  localparam logic [11:0] OFF_MSC_CLR = 12'h034;
  localparam logic [11:0] OFF_MSC_EN  = 12'h038;
  localparam logic [11:0] OFF_BRG_EN  = 12'h048;
  localparam logic [11:0] OFF_MSC_NS  = 12'h04C;
  localparam logic [11:0] OFF_ID_LO   = 12'hFD0;

  localparam logic [31:0] PPC_EN_MASK = 32'h00F0_00F3;
  localparam logic [31:0] BRG_EN_MASK = 32'hFFFF_0000;

  localparam logic [7:0] ID_SEC = 8'hA0;
  localparam logic [7:0] ID_NS  = 8'hC0;

  // secure-window write strobe indices
  localparam int SW_RESP    = 0;
  localparam int SW_NSC     = 1;
  localparam int SW_PPC_CLR = 2;
  localparam int SW_PPC_EN  = 3;
  localparam int SW_MSC_CLR = 4;
  localparam int SW_MSC_EN  = 5;
  localparam int SW_BRG_EN  = 6;
  localparam int SW_MSC_NS  = 7;
  localparam int SW_N       = 8;

  // status / enable bit of peripheral filter interrupt j
  function automatic int irq_pos(input int j);
    if (j < 2)      return j;
    else if (j < 6) return j + 2;
    else            return j + 14;
  endfunction

  // word address -> protection mask reference
  function automatic mref_t map_mask(input logic ns_win, input logic [9:0] wa);
    mref_t      r;
    logic [3:0] nib;
    logic [1:0] idx;
    logic       hi;
    logic       lo;
    logic       ok;
    logic [3:0] g;
    r.kind = MK_NONE;
    r.grp  = '0;
    idx = wa[1:0];
    hi  = (wa[9:6] == 4'h0) && (wa[5:2] >= 4'h9) && (wa[5:2] <= 4'hC);
    lo  = (wa[9:6] == 4'h0) && (wa[5:2] >= 4'h5) && (wa[5:2] <= 4'h8);
    nib = hi ? (wa[5:2] - 4'h4) : wa[5:2];
    ok  = 1'b0;
    g   = '0;
    case (nib)
      4'h5: begin ok = (idx == 2'd0); g = 4'd0; end
      4'h6: begin ok = 1'b1; g = 4'd7 + {2'b00, idx}; end
      4'h7: begin ok = (idx < 2'd2); g = 4'd1 + {2'b00, idx}; end
      4'h8: begin ok = 1'b1; g = 4'd3 + {2'b00, idx}; end
      default: ok = 1'b0;
    endcase
    if (ok && (hi || lo)) begin
      r.grp = g;
      if (ns_win) r.kind = hi ? MK_NSP : MK_NONE;
      else        r.kind = hi ? MK_SP : MK_NS;
    end
    return r;
  endfunction
endpackage

// File: rtl/scb_decode.sv
module scb_decode
  import scb_pkg::*;
(
  input  logic            bus_en,
  input  logic            bus_wr,
  input  logic            bus_ns,
  input  logic [9:0]      waddr,
  input  logic [1:0]      bus_size,
  output logic            wr_go,
  output logic            rd_go,
  output mref_t           mref,
  output logic [SW_N-1:0] sec_we
);
  always_comb begin
    wr_go = bus_en && bus_wr && (bus_size == 2'd2);
    rd_go = bus_en && !bus_wr;
    mref  = map_mask(bus_ns, waddr);
    sec_we = '0;
    if (wr_go && !bus_ns) begin
      sec_we[SW_RESP]    = (waddr == OFF_RESP[11:2]);
      sec_we[SW_NSC]     = (waddr == OFF_NSC[11:2]);
      sec_we[SW_PPC_CLR] = (waddr == OFF_PPC_CLR[11:2]);
      sec_we[SW_PPC_EN]  = (waddr == OFF_PPC_EN[11:2]);
      sec_we[SW_MSC_CLR] = (waddr == OFF_MSC_CLR[11:2]);
      sec_we[SW_MSC_EN]  = (waddr == OFF_MSC_EN[11:2]);
      sec_we[SW_BRG_EN]  = (waddr == OFF_BRG_EN[11:2]);
      sec_we[SW_MSC_NS]  = (waddr == OFF_MSC_NS[11:2]);
    end
  end
endmodule

// File: rtl/scb_group.sv
module scb_group #(
  parameter int NPORT = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_ns,
  input  logic             we_sp,
  input  logic             we_nsp,
  input  logic [NPORT-1:0] wdata,
  output logic [NPORT-1:0] ns_q,
  output logic [NPORT-1:0] sp_q,
  output logic [NPORT-1:0] nsp_q,
  output logic [NPORT-1:0] ap
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ns_q  <= '0;
      sp_q  <= '0;
      nsp_q <= '0;
    end else begin
      if (we_ns)  ns_q  <= wdata;
      if (we_sp)  sp_q  <= wdata;
      if (we_nsp) nsp_q <= wdata;
    end
  end

  for (genvar i = 0; i < NPORT; i++) begin : g_ap
    assign ap[i] = ns_q[i] ? nsp_q[i] : sp_q[i];
  end

  // R1: a mask changes only on its own write strobe
  a_r1_ns_only_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !we_ns |=> $stable(ns_q));
  // R2: the non-secure privilege mask changes only on its own strobe
  a_r2_nsp_only_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !we_nsp |=> $stable(nsp_q));
endmodule

// File: rtl/sec_ctrl_bank.sv
module sec_ctrl_bank
  import scb_pkg::*;
#(
  parameter int NPORT    = 16,
  parameter int NEXP_MPC = 4,
  parameter int NEXP_MSC = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_en,
  input  logic                    bus_wr,
  input  logic                    bus_ns,
  input  logic [11:0]             bus_addr,
  input  logic [1:0]              bus_size,
  input  logic [31:0]             bus_wdata,
  output logic [31:0]             bus_rdata,
  output logic                    bus_rvalid,
  input  logic                    mpc_int_in,
  input  logic [NEXP_MPC-1:0]     mpc_exp_in,
  input  logic [NEXP_MSC-1:0]     msc_exp_in,
  input  logic [NIRQ-1:0]         ppc_stat_in,
  output logic [NGRP*NPORT-1:0]   grp_nonsec,
  output logic [NGRP*NPORT-1:0]   grp_ap,
  output logic [NIRQ-1:0]         ppc_irq_en,
  output logic [NIRQ-1:0]         ppc_irq_clr,
  output logic [NEXP_MSC-1:0]     msc_clr,
  output logic [NEXP_MSC-1:0]     msc_ns,
  output logic                    msc_irq,
  output logic                    resp_cfg,
  output logic [1:0]              nsc_cfg
);
  localparam int LANE_SH = 3;

  logic            wr_go, rd_go;
  mref_t           mref;
  logic [SW_N-1:0] sec_we;
  logic [9:0]      waddr;

  assign waddr = bus_addr[11:2];

  scb_decode u_dec (
    .bus_en   (bus_en),
    .bus_wr   (bus_wr),
    .bus_ns   (bus_ns),
    .waddr    (waddr),
    .bus_size (bus_size),
    .wr_go    (wr_go),
    .rd_go    (rd_go),
    .mref     (mref),
    .sec_we   (sec_we)
  );

  logic [NPORT-1:0] g_ns  [NGRP];
  logic [NPORT-1:0] g_sp  [NGRP];
  logic [NPORT-1:0] g_nsp [NGRP];
  logic [NPORT-1:0] g_ap  [NGRP];

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    logic hit;
    assign hit = wr_go && (mref.grp == 4'(g));
    scb_group #(.NPORT(NPORT)) u_grp (
      .clk    (clk),
      .rst_n  (rst_n),
      .we_ns  (hit && mref.kind == MK_NS),
      .we_sp  (hit && mref.kind == MK_SP),
      .we_nsp (hit && mref.kind == MK_NSP),
      .wdata  (bus_wdata[NPORT-1:0]),
      .ns_q   (g_ns[g]),
      .sp_q   (g_sp[g]),
      .nsp_q  (g_nsp[g]),
      .ap     (g_ap[g])
    );
    assign grp_nonsec[g*NPORT +: NPORT] = g_ns[g];
    assign grp_ap[g*NPORT +: NPORT]     = g_ap[g];
  end

  // secure-only control state
  logic                resp_q;
  logic [1:0]          nsc_q;
  logic [31:0]         ppc_en_q, msc_en_q, brg_en_q;
  logic [NEXP_MSC-1:0] msc_ns_q, msc_clr_q;
  logic [NIRQ-1:0]     ppc_clr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_q    <= 1'b0;
      nsc_q     <= '0;
      ppc_en_q  <= '0;
      msc_en_q  <= '0;
      brg_en_q  <= '0;
      msc_ns_q  <= '0;
      msc_clr_q <= '0;
      ppc_clr_q <= '0;
    end else begin
      if (sec_we[SW_RESP])   resp_q   <= bus_wdata[0];
      if (sec_we[SW_NSC])    nsc_q    <= bus_wdata[1:0];
      if (sec_we[SW_PPC_EN]) ppc_en_q <= bus_wdata & PPC_EN_MASK;
      if (sec_we[SW_MSC_EN]) msc_en_q <= bus_wdata;
      if (sec_we[SW_BRG_EN]) brg_en_q <= bus_wdata & BRG_EN_MASK;
      if (sec_we[SW_MSC_NS]) msc_ns_q <= bus_wdata[16 +: NEXP_MSC];
      msc_clr_q <= sec_we[SW_MSC_CLR] ? bus_wdata[16 +: NEXP_MSC] : '0;
      for (int j = 0; j < NIRQ; j++)
        ppc_clr_q[j] <= sec_we[SW_PPC_CLR] && bus_wdata[irq_pos(j)];
    end
  end

  // status packing
  logic [31:0] mpc_stat, msc_stat, ppc_stat;
  always_comb begin
    mpc_stat = '0;
    mpc_stat[0] = mpc_int_in;
    mpc_stat[16 +: NEXP_MPC] = mpc_exp_in;
    msc_stat = '0;
    msc_stat[16 +: NEXP_MSC] = msc_exp_in;
    ppc_stat = '0;
    for (int j = 0; j < NIRQ; j++) begin
      ppc_stat[irq_pos(j)] = ppc_stat_in[j];
      ppc_irq_en[j]        = ppc_en_q[irq_pos(j)];
    end
  end

  assign msc_irq     = |(msc_stat & msc_en_q);
  assign resp_cfg    = resp_q;
  assign nsc_cfg     = nsc_q;
  assign msc_ns      = msc_ns_q;
  assign msc_clr     = msc_clr_q;
  assign ppc_irq_clr = ppc_clr_q;

  // read mux
  logic [31:0] rword, rshift;
  logic [11:0] woff;
  assign woff = {waddr, 2'b00};

  always_comb begin
    rword = '0;
    if (woff >= OFF_ID_LO) begin
      rword[7:0] = (bus_ns ? ID_NS : ID_SEC) + {4'b0000, waddr[3:0]} - 8'd4;
    end else if (mref.kind != MK_NONE) begin
      case (mref.kind)
        MK_NS:   rword[NPORT-1:0] = g_ns[mref.grp];
        MK_SP:   rword[NPORT-1:0] = g_sp[mref.grp];
        default: rword[NPORT-1:0] = g_nsp[mref.grp];
      endcase
    end else if (!bus_ns) begin
      case (woff)
        OFF_RESP:   rword[0]   = resp_q;
        OFF_NSC:    rword[1:0] = nsc_q;
        OFF_MPC_ST: rword = mpc_stat;
        OFF_PPC_ST: rword = ppc_stat;
        OFF_PPC_EN: rword = ppc_en_q;
        OFF_MSC_ST: rword = msc_stat;
        OFF_MSC_EN: rword = msc_en_q;
        OFF_BRG_EN: rword = brg_en_q;
        OFF_MSC_NS: rword[16 +: NEXP_MSC] = msc_ns_q;
        default:    rword = '0;
      endcase
    end
    rshift = rword >> {bus_addr[1:0], LANE_SH'(0)};
    case (bus_size)
      2'd0:    rshift = rshift & 32'h0000_00FF;
      2'd1:    rshift = rshift & 32'h0000_FFFF;
      default: rshift = rshift;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= rd_go;
      if (rd_go) bus_rdata <= rshift;
    end
  end

  // R4: narrow writes leave all control state untouched
  a_r4_narrow_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_wr && bus_size != 2'd2) |=>
      ($stable(grp_nonsec) && $stable(grp_ap) && $stable(ppc_en_q) && $stable(msc_en_q) && $stable(nsc_q)));
  // R2: non-secure window writes cannot alter secure-only state
  a_r2_ns_window_limited: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_wr && bus_ns) |=>
      ($stable(grp_nonsec) && $stable(ppc_en_q) && $stable(resp_q) && $stable(msc_ns_q)));
  // R10: a clear pulse follows a secure word write to the clear offset
  a_r10_clr_pulse_source: assert property (@(posedge clk) disable iff (!rst_n)
    (|ppc_irq_clr) |-> $past(bus_en && bus_wr && !bus_ns && bus_size == 2'd2 && waddr == OFF_PPC_CLR[11:2]));
  // R9: combined interrupt needs an active expansion line
  a_r9_msc_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
    msc_irq |-> (|msc_exp_in));
  // R14: read data valid only after a read request
  a_r14_rvalid_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rvalid |-> $past(bus_en && !bus_wr));
  // R6: enable register holds no bit outside its mask
  a_r6_enable_masked: assert property (@(posedge clk) disable iff (!rst_n)
    ((ppc_en_q & ~PPC_EN_MASK) == 32'h0) && ((brg_en_q & ~BRG_EN_MASK) == 32'h0));
endmodule

// File: tb/sim_sec_ctrl_bank.sv
module sim_sec_ctrl_bank;
  localparam int NP = 16;
  localparam int NG = 11;
  localparam int NI = 10;
  localparam int NM = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_en = 0, bus_wr = 0, bus_ns = 0;
  logic [11:0] bus_addr = '0;
  logic [1:0]  bus_size = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic        mpc_int_in = 0;
  logic [NM-1:0] mpc_exp_in = '0, msc_exp_in = '0;
  logic [NI-1:0] ppc_stat_in = '0;
  logic [NG*NP-1:0] grp_nonsec, grp_ap;
  logic [NI-1:0] ppc_irq_en, ppc_irq_clr;
  logic [NM-1:0] msc_clr, msc_ns;
  logic msc_irq, resp_cfg;
  logic [1:0] nsc_cfg;

  always #2 clk = ~clk;

  sec_ctrl_bank u0 (.*);

  int checks = 0, failures = 0;
  bit done = 0;

  // bench model
  logic [NP-1:0] m_ns [NG], m_sp [NG], m_nsp [NG];
  logic [31:0] m_ppcen, m_mscen, m_brgen;
  logic [NM-1:0] m_mscns, e_mclr;
  logic [NI-1:0] e_pclr;
  logic m_resp;
  logic [1:0] m_nsc;

  task automatic chk(string tag, logic [191:0] act, logic [191:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int bpos(int j);
    int t [NI] = '{0, 1, 4, 5, 6, 7, 20, 21, 22, 23};
    return t[j];
  endfunction

  // returns kind*16+group (kind 1 ns, 2 sp, 3 nsp) or -1
  function automatic int bdec(bit ns, int off);
    int nib = (off >> 4) & 15;
    int idx = (off >> 2) & 3;
    int k;
    int g = -1;
    if ((off >> 8) != 0) return -1;
    if (nib >= 9 && nib <= 12) begin k = ns ? 3 : 2; nib -= 4; end
    else if (nib >= 5 && nib <= 8) begin if (ns) return -1; k = 1; end
    else return -1;
    case (nib)
      5: if (idx == 0) g = 0;
      6: g = 7 + idx;
      7: if (idx < 2) g = 1 + idx;
      8: g = 3 + idx;
      default: g = -1;
    endcase
    if (g < 0) return -1;
    return k * 16 + g;
  endfunction

  function automatic logic [31:0] exp_word(bit ns, int off);
    int d = bdec(ns, off);
    logic [31:0] w = '0;
    if (off >= 'hFD0) return 32'((ns ? 8'hC0 : 8'hA0) + 8'((off - 'hFD0) / 4));
    if (d >= 0) begin
      case (d >> 4)
        1: w[NP-1:0] = m_ns[d & 15];
        2: w[NP-1:0] = m_sp[d & 15];
        default: w[NP-1:0] = m_nsp[d & 15];
      endcase
      return w;
    end
    if (ns) return 0;
    case (off)
      'h10: w = 32'(m_resp);
      'h14: w = 32'(m_nsc);
      'h1C: begin w[0] = mpc_int_in; w[19:16] = mpc_exp_in; end
      'h20: for (int j = 0; j < NI; j++) w[bpos(j)] = ppc_stat_in[j];
      'h28: w = m_ppcen;
      'h30: w[19:16] = msc_exp_in;
      'h38: w = m_mscen;
      'h48: w = m_brgen;
      'h4C: w[19:16] = m_mscns;
      default: w = 0;
    endcase
    return w;
  endfunction

  task automatic model_write(bit ns, int a, logic [1:0] sz, logic [31:0] d);
    int off = a & 'hFFC;
    int r = bdec(ns, off);
    if (sz != 2) return;
    if (r >= 0) begin
      case (r >> 4)
        1: m_ns[r & 15] = d[NP-1:0];
        2: m_sp[r & 15] = d[NP-1:0];
        default: m_nsp[r & 15] = d[NP-1:0];
      endcase
    end else if (!ns) begin
      case (off)
        'h10: m_resp = d[0];
        'h14: m_nsc = d[1:0];
        'h24: for (int j = 0; j < NI; j++) e_pclr[j] = d[bpos(j)];
        'h28: m_ppcen = d & 32'h00F000F3;
        'h34: e_mclr = d[19:16];
        'h38: m_mscen = d;
        'h48: m_brgen = d & 32'hFFFF0000;
        'h4C: m_mscns = d[19:16];
        default: ;
      endcase
    end
  endtask

  task automatic check_outs();
    logic [NG*NP-1:0] ens, eap;
    logic [NI-1:0] een;
    logic [31:0] mst;
    for (int g = 0; g < NG; g++)
      for (int i = 0; i < NP; i++) begin
        ens[g*NP+i] = m_ns[g][i];
        eap[g*NP+i] = m_ns[g][i] ? m_nsp[g][i] : m_sp[g][i];
      end
    for (int j = 0; j < NI; j++) een[j] = m_ppcen[bpos(j)];
    mst = '0; mst[19:16] = msc_exp_in;
    chk("R1 grp_nonsec", 192'(grp_nonsec), 192'(ens));
    chk("R3 grp_ap", 192'(grp_ap), 192'(eap));
    chk("R6 ppc_irq_en", 192'(ppc_irq_en), 192'(een));
    chk("R7 cfg outputs", 192'({resp_cfg, nsc_cfg}), 192'({m_resp, m_nsc}));
    chk("R10 pulses and msc_ns", 192'({ppc_irq_clr, msc_clr, msc_ns}), 192'({e_pclr, e_mclr, m_mscns}));
    chk("R9 msc_irq", 192'(msc_irq), 192'(|(mst & m_mscen)));
  endtask

  task automatic do_write(bit ns, int a, logic [1:0] sz, logic [31:0] d);
    @(negedge clk);
    bus_en = 1; bus_wr = 1; bus_ns = ns; bus_addr = 12'(a); bus_size = sz; bus_wdata = d;
    e_pclr = '0; e_mclr = '0;
    model_write(ns, a, sz, d);
    @(negedge clk);
    bus_en = 0; bus_wr = 0;
    check_outs();
  endtask

  task automatic do_read(bit ns, int a, logic [1:0] sz, string tag);
    logic [31:0] e;
    @(negedge clk);
    bus_en = 1; bus_wr = 0; bus_ns = ns; bus_addr = 12'(a); bus_size = sz;
    e_pclr = '0; e_mclr = '0;
    e = exp_word(ns, a & 'hFFC) >> (8 * (a & 3));
    if (sz == 0) e &= 32'hFF; else if (sz == 1) e &= 32'hFFFF;
    @(negedge clk);
    bus_en = 0;
    chk("R14 rvalid", 192'(bus_rvalid), 192'(1));
    chk(tag, 192'(bus_rdata), 192'(e));
    @(negedge clk);
    chk("R14 rvalid low", 192'(bus_rvalid), 192'(0));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd24601));
    for (int g = 0; g < NG; g++) begin m_ns[g] = 0; m_sp[g] = 0; m_nsp[g] = 0; end
    m_ppcen = 0; m_mscen = 0; m_brgen = 0; m_mscns = 0; e_mclr = 0; e_pclr = 0;
    m_resp = 0; m_nsc = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12 reset state
    chk("R12 reset nonsec", 192'(grp_nonsec), 192'(0));
    chk("R12 reset ap/cfg", 192'({grp_ap, resp_cfg, nsc_cfg, ppc_irq_en, msc_ns}), 192'(0));
    do_read(0, 'h28, 2, "R12 reset ppc enable");

    // R1 secure masks
    do_write(0, 'h64, 2, 32'h1234_A5A5);
    do_write(0, 'hA4, 2, 32'h0000_0FF0);
    do_write(0, 'h74, 2, 32'hFFFF_8001);
    do_read(0, 'h64, 2, "R1 readback ns mask");
    do_read(0, 'hA4, 2, "R1 readback sp mask");
    do_write(0, 'h54, 2, 32'hFFFF);  // hole after internal AHB
    do_read(0, 'h54, 2, "R11 hole reads zero");

    // R2 non-secure window
    do_write(1, 'h64, 2, 32'hFFFF);
    do_write(1, 'h10, 2, 32'h1);
    do_write(1, 'hA4, 2, 32'h3C3C);
    do_read(1, 'hA4, 2, "R2 ns window nsp");
    do_read(0, 'hA4, 2, "R2 secure sp unchanged");
    do_read(1, 'h28, 2, "R2 ns window other reads zero");

    // R4 narrow writes
    do_write(0, 'h74, 0, 32'h0);
    do_write(0, 'h28, 1, 32'hFFFF_FFFF);
    do_read(0, 'h74, 2, "R4 narrow write ignored");

    // R5 lanes
    do_read(0, 'h66, 1, "R5 half lane 2");
    do_read(0, 'h67, 1, "R5 half lane 3");
    do_read(0, 'h65, 0, "R5 byte lane 1");

    // R6 masks
    do_write(0, 'h28, 2, 32'hFFFF_FFFF);
    do_read(0, 'h28, 2, "R6 ppc enable mask");
    do_write(0, 'h48, 2, 32'hFFFF_FFFF);
    do_read(0, 'h48, 2, "R6 bridge enable mask");

    // R7 configs
    do_write(0, 'h14, 2, 32'hFFFF_FFFF);
    do_write(0, 'h10, 2, 32'h3);
    do_read(0, 'h14, 2, "R7 nsc readback");

    // R8 / R9 status and interrupt
    @(negedge clk);
    mpc_int_in = 1; mpc_exp_in = 4'b1010; msc_exp_in = 4'b0100; ppc_stat_in = 10'b10_0100_0101;
    do_read(0, 'h1C, 2, "R8 mpc status");
    do_read(0, 'h30, 2, "R8 msc status");
    do_read(0, 'h20, 2, "R8 ppc status");
    do_write(0, 'h38, 2, 32'h0004_0000);
    do_write(0, 'h38, 2, 32'h0008_0000);
    @(negedge clk); msc_exp_in = 4'b1000; #1;
    chk("R9 msc_irq follows input", 192'(msc_irq), 192'(1));

    // R10 pulses
    do_write(0, 'h24, 2, 32'h00F0_00F3);
    do_write(0, 'h34, 2, 32'h000F_0000);
    do_write(0, 'h4C, 2, 32'h0005_0000);
    do_read(0, 'h4C, 2, "R10 msc_ns readback");

    // R11 read-only and write-only
    do_read(0, 'h40, 2, "R11 bridge status zero");
    do_read(0, 'h24, 2, "R11 clear reads zero");
    do_write(0, 'h1C, 2, 32'hFFFF_FFFF);
    do_read(0, 'h1C, 2, "R11 status write ignored");

    // R13 identification
    do_read(0, 'hFD0, 2, "R13 id secure first");
    do_read(1, 'hFFC, 2, "R13 id ns last");
    do_read(1, 'hFE4, 0, "R13 id ns byte");

    // random mix
    for (int n = 0; n < 600; n++) begin
      bit ns = $urandom_range(0, 1);
      int a;
      logic [1:0] sz = ($urandom_range(0, 4) == 0) ? 2'($urandom_range(0, 3)) : 2'd2;
      a = ($urandom_range(0, 7) == 0) ? 'hFC0 + $urandom_range(0, 63) : $urandom_range(0, 'hFF);
      @(negedge clk);
      mpc_int_in = 1'($urandom); mpc_exp_in = 4'($urandom); msc_exp_in = 4'($urandom);
      ppc_stat_in = 10'($urandom);
      if ($urandom_range(0, 1) == 0) do_write(ns, a & 'hFFC, sz, $urandom);
      else do_read(ns, a, sz, "R5 random read");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule